// File: doc/BRIEF.md
# Packet Number Replay Window Checker

This block holds the packet number (PN) state of every security association in a frame protection pipeline. Each association has two counters. The transmit counter holds the next PN to hand out. The receive counter holds the lowest PN that counts as new.

A transmit request reads the association's counter and returns that value as the frame's PN, then advances the counter by one. When the issued PN lies strictly above a programmable limit, the response also raises a rekey flag.

A receive request carries the PN taken from the frame and the pass/fail result of the tag check. The block builds the lowest acceptable PN by subtracting the window size from the receive counter, with the result clamped at zero. A frame below that bound is reported late. The receive counter moves forward only when the frame is not late and the tag check passed.

Requests arrive one per cycle at most. The response appears one cycle later, qualified by a single completion strobe.

Top module: `pn_replay_guard`

## Requirements
- R1: After reset, every association's transmit counter and receive counter equal 1, and `done` is low.
- R2: `done` is high for exactly the cycle that follows a cycle with `req_valid` high, and low in every other cycle. The other response outputs are zero whenever `done` is low.
- R3: A transmit request (`req_rx`=0) returns the association's stored transmit counter on `rsp_pn`, then increments that counter. Each association counts independently of the others.
- R4: On a transmit response, `rsp_exhausted` is 1 exactly when the issued PN is strictly greater than `cfg_pn_limit`. A PN equal to the limit does not flag.
- R5: A receive request (`req_rx`=1) reports `rsp_late`=1 when `req_pn` is below the receive counter minus `cfg_win_size`. A late frame never changes the stored state.
- R6: When `cfg_win_size` is 0, only PNs greater than or equal to the receive counter are accepted.
- R7: An accepted receive frame sets the receive counter to the larger of its old value and `req_pn`+1. A PN inside the window but below the counter never lowers it.
- R8: A receive frame with `req_auth_ok`=0 gives `rsp_accept`=0 and leaves the receive counter unchanged.
- R9: The subtraction of the window from the receive counter clamps at zero. With the counter at 1 and a window larger than 1, PN 0 is accepted.
- R10: On a receive response, `rsp_accept` is 1 exactly when the frame is not late and `req_auth_ok` was 1. `rsp_pn` and `rsp_exhausted` are 0 on receive responses, and `rsp_late` and `rsp_accept` are 0 on transmit responses.
- R11: Transmit and receive state are separate. Receive traffic on an association does not alter the PNs that association issues on transmit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_pn_limit | input | 32 | Transmit PN limit; a PN above it requests a rekey |
| cfg_win_size | input | 32 | Receive replay window size |
| req_valid | input | 1 | A request is present this cycle |
| req_rx | input | 1 | 1 = receive check, 0 = transmit issue |
| req_sa | input | IDX_W (3) | Association index |
| req_pn | input | 32 | PN carried in the received frame (receive only) |
| req_auth_ok | input | 1 | Tag check passed (receive only) |
| done | output | 1 | Completion strobe; qualifies all response outputs |
| rsp_pn | output | 32 | PN issued to the transmitted frame |
| rsp_exhausted | output | 1 | Issued PN exceeds the limit; rekey needed |
| rsp_late | output | 1 | Received PN lies below the window |
| rsp_accept | output | 1 | Received frame accepted and state committed |

## Verification
The bench probes the limit on both sides. A PN equal to `cfg_pn_limit` must not flag, and the next one must. A design that compares with greater-or-equal would request rekeying one frame early.

The bench sends a failed-verdict frame with a far-ahead PN, then a probe with the verdict forced to fail. The probe is late only if the failed frame moved the counter, so this exposes a design that commits before the verdict. An in-window PN below the counter is followed by a probe with a zero window. This catches a design that takes the frame's PN instead of the maximum.

An enormous window at counter 1 checks the clamped subtraction; a wrapping design would reject PN 0. Interleaved receive and transmit traffic on one association shows whether the two counters are shared.

// File: rtl/pn_guard_pkg.sv
// Package: shared PN type and saturating helpers for the replay window checker.
// Assumes PNs are unsigned 32-bit quantities that never wrap.
package pn_guard_pkg;

    localparam int PN_W = 32;

    typedef logic [PN_W-1:0] pn_t;

    localparam pn_t PN_MAX = '1;

    // Subtract b from a, clamping at zero.
    function automatic pn_t pn_sat_sub(input pn_t a, input pn_t b);
        return (a > b) ? (a - b) : '0;
    endfunction

    // Increment a, holding at the all-ones value.
    function automatic pn_t pn_sat_inc(input pn_t a);
        return (a == PN_MAX) ? PN_MAX : (a + 1'b1);
    endfunction

endpackage

// File: rtl/pn_state_bank.sv
// Module: pn_state_bank
// One PN counter per association, with one combinational read port and one write port.
// Assumes at most one write per cycle. All counters reset to RESET_VAL.
module pn_state_bank
    import pn_guard_pkg::*;
#(
    parameter int  NUM_SA    = 8,
    parameter pn_t RESET_VAL = 32'd1,
    localparam int IDX_W     = (NUM_SA > 1) ? $clog2(NUM_SA) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output pn_t              rd_data,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  pn_t              wr_data
);

    pn_t cnt [NUM_SA];

    genvar g;
    generate
        for (g = 0; g < NUM_SA; g++) begin : g_entry
            // Hold one association's counter; load it when addressed by a write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cnt[g] <= RESET_VAL;
                else if (wr_en && (wr_idx == IDX_W'(g)))
                    cnt[g] <= wr_data;
            end
        end
    endgenerate

    // Read the addressed counter.
    always_comb rd_data = cnt[rd_idx];

endmodule

// File: rtl/pn_tx_issue.sv
// Module: pn_tx_issue
// Combinational transmit step: issues the stored PN, computes the advanced value
// and compares the issued PN against the limit.
// Assumes the caller commits next_pn only on a transmit request.
module pn_tx_issue
    import pn_guard_pkg::*;
(
    input  pn_t  cur_pn,
    input  pn_t  limit,
    output pn_t  issue_pn,
    output pn_t  next_pn,
    output logic exhausted
);

    // Issue the current value, advance it and flag a PN above the limit.
    always_comb begin
        issue_pn  = cur_pn;
        next_pn   = pn_sat_inc(cur_pn);
        exhausted = (cur_pn > limit);
    end

endmodule

// File: rtl/pn_rx_window.sv
// Module: pn_rx_window
// Combinational receive check: computes the lower window bound, the late
// verdict, the accept decision and the updated receive counter.
// Assumes the caller writes new_next only when accept is high.
module pn_rx_window
    import pn_guard_pkg::*;
(
    input  pn_t  cur_next,
    input  pn_t  win_size,
    input  pn_t  rx_pn,
    input  logic auth_ok,
    output logic late,
    output logic accept,
    output pn_t  new_next
);

    pn_t low_bound;
    pn_t rx_succ;

    // Build the clamped lower bound, the verdicts and the forward-only update.
    always_comb begin
        low_bound = pn_sat_sub(cur_next, win_size);
        rx_succ   = pn_sat_inc(rx_pn);
        late      = (rx_pn < low_bound);
        accept    = !late && auth_ok;
        new_next  = (rx_succ > cur_next) ? rx_succ : cur_next;
    end

endmodule

// File: rtl/pn_replay_guard.sv
// Module: pn_replay_guard (top)
// Per-association PN issue for transmit and replay-window acceptance for receive.
// A request is taken in one cycle and its response is registered for the next,
// qualified by done. Assumes one request per cycle at most. The receive counter
// commits only on a non-late frame with a passing tag verdict.
module pn_replay_guard
    import pn_guard_pkg::*;
#(
    parameter int  NUM_SA = 8,
    localparam int IDX_W  = (NUM_SA > 1) ? $clog2(NUM_SA) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [31:0]      cfg_pn_limit,
    input  logic [31:0]      cfg_win_size,
    input  logic             req_valid,
    input  logic             req_rx,
    input  logic [IDX_W-1:0] req_sa,
    input  logic [31:0]      req_pn,
    input  logic             req_auth_ok,
    output logic             done,
    output logic [31:0]      rsp_pn,
    output logic             rsp_exhausted,
    output logic             rsp_late,
    output logic             rsp_accept
);

    pn_t  tx_cur, tx_issue, tx_next;
    pn_t  rx_cur, rx_next;
    logic tx_exh, rx_late, rx_acc;
    logic tx_we, rx_we;
    logic dir_rx_q;

    // Qualify the write enables with the request kind and verdict.
    always_comb begin
        tx_we = req_valid && !req_rx;
        rx_we = req_valid && req_rx && rx_acc;
    end

    pn_state_bank #(.NUM_SA(NUM_SA), .RESET_VAL(32'd1)) u_tx_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (req_sa),
        .rd_data (tx_cur),
        .wr_en   (tx_we),
        .wr_idx  (req_sa),
        .wr_data (tx_next)
    );

    pn_state_bank #(.NUM_SA(NUM_SA), .RESET_VAL(32'd1)) u_rx_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (req_sa),
        .rd_data (rx_cur),
        .wr_en   (rx_we),
        .wr_idx  (req_sa),
        .wr_data (rx_next)
    );

    pn_tx_issue u_tx (
        .cur_pn    (tx_cur),
        .limit     (cfg_pn_limit),
        .issue_pn  (tx_issue),
        .next_pn   (tx_next),
        .exhausted (tx_exh)
    );

    pn_rx_window u_rx (
        .cur_next (rx_cur),
        .win_size (cfg_win_size),
        .rx_pn    (req_pn),
        .auth_ok  (req_auth_ok),
        .late     (rx_late),
        .accept   (rx_acc),
        .new_next (rx_next)
    );

    // Register the response, zeroing the fields that do not apply to the request kind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done          <= 1'b0;
            dir_rx_q      <= 1'b0;
            rsp_pn        <= '0;
            rsp_exhausted <= 1'b0;
            rsp_late      <= 1'b0;
            rsp_accept    <= 1'b0;
        end else begin
            done          <= req_valid;
            dir_rx_q      <= req_rx;
            rsp_pn        <= tx_we ? tx_issue : '0;
            rsp_exhausted <= tx_we && tx_exh;
            rsp_late      <= req_valid && req_rx && rx_late;
            rsp_accept    <= req_valid && req_rx && rx_acc;
        end
    end

    // R2: the strobe follows a request by exactly one cycle
    a_r2_done_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> done);
    a_r2_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !done);

    // R2: response fields are quiet without the strobe
    a_r2_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (rsp_pn == '0 && !rsp_exhausted && !rsp_late && !rsp_accept));

    // R4: rekey flag is a strict comparison against the limit seen at request time
    a_r4_exhaust_strict: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !dir_rx_q) |-> (rsp_exhausted == (rsp_pn > $past(cfg_pn_limit))));

    // R5: a late frame is never accepted
    a_r5_late_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_late && rsp_accept));

    // R7: the receive counter only moves forward
    a_r7_forward_only: assert property (@(posedge clk) disable iff (!rst_n)
        rx_we |-> (rx_next >= rx_cur));

    // R8: a failed verdict never commits
    a_r8_fail_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_rx && !req_auth_ok) |-> !rx_we);

    // R3: an issued PN is the value the next frame on that association builds on
    a_r3_tx_advance: assert property (@(posedge clk) disable iff (!rst_n)
        tx_we |-> (tx_next == tx_cur + 1'b1 || tx_cur == PN_MAX));

endmodule

// File: tb/pn_replay_guard_bench.sv
module pn_replay_guard_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_SA     = 8;
    localparam int IDX_W      = $clog2(NUM_SA);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [31:0]      cfg_pn_limit = 32'd3;
    logic [31:0]      cfg_win_size = 32'd0;
    logic             req_valid = 1'b0;
    logic             req_rx = 1'b0;
    logic [IDX_W-1:0] req_sa = '0;
    logic [31:0]      req_pn = '0;
    logic             req_auth_ok = 1'b0;
    logic             done;
    logic [31:0]      rsp_pn;
    logic             rsp_exhausted, rsp_late, rsp_accept;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pn_replay_guard #(.NUM_SA(NUM_SA)) u_pn_replay_guard (
        .clk(clk), .rst_n(rst_n), .cfg_pn_limit(cfg_pn_limit), .cfg_win_size(cfg_win_size),
        .req_valid(req_valid), .req_rx(req_rx), .req_sa(req_sa), .req_pn(req_pn),
        .req_auth_ok(req_auth_ok), .done(done), .rsp_pn(rsp_pn),
        .rsp_exhausted(rsp_exhausted), .rsp_late(rsp_late), .rsp_accept(rsp_accept)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One request; on return the response sits registered on the outputs.
    task automatic send(input logic rx, input int sa, input logic [31:0] pn, input logic ok);
        @(negedge clk);
        req_valid = 1'b1; req_rx = rx; req_sa = IDX_W'(sa); req_pn = pn; req_auth_ok = ok;
        @(negedge clk);
        req_valid = 1'b0; req_rx = 1'b0; req_pn = '0; req_auth_ok = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 done after reset", {31'd0, done}, 32'd1 - 32'd1);
        send(1'b0, 0, 0, 1'b0);
        check("R1 first tx pn", rsp_pn, 32'd1);
        check("R2 done strobe", {31'd0, done}, 32'd1);
        @(negedge clk);
        check("R2 done drops", {31'd0, done}, 32'd0);
        check("R2 quiet pn", rsp_pn, 32'd0);
    endtask

    task automatic t_tx_limit;
        send(1'b0, 0, 0, 1'b0);
        check("R3 second pn", rsp_pn, 32'd2);
        check("R4 below limit", {31'd0, rsp_exhausted}, 32'd0);
        send(1'b0, 0, 0, 1'b0);
        check("R4 equal limit pn", rsp_pn, 32'd3);
        check("R4 equal limit no flag", {31'd0, rsp_exhausted}, 32'd0);
        send(1'b0, 0, 0, 1'b0);
        check("R4 above limit pn", rsp_pn, 32'd4);
        check("R4 above limit flag", {31'd0, rsp_exhausted}, 32'd1);
        check("R10 tx no late", {31'd0, rsp_late}, 32'd0);
        send(1'b0, 1, 0, 1'b0);
        check("R3 independent sa", rsp_pn, 32'd1);
    endtask

    task automatic t_rx_zero_window;
        cfg_win_size = 32'd0;
        send(1'b1, 2, 32'd1, 1'b1);
        check("R10 accept first", {31'd0, rsp_accept}, 32'd1);
        check("R10 rx pn zero", rsp_pn, 32'd0);
        send(1'b1, 2, 32'd1, 1'b1);
        check("R6 replay late", {31'd0, rsp_late}, 32'd1);
        check("R5 late not accepted", {31'd0, rsp_accept}, 32'd0);
        send(1'b1, 2, 32'd5, 1'b1);
        check("R7 jump accepted", {31'd0, rsp_accept}, 32'd1);
        send(1'b1, 2, 32'd5, 1'b0);
        check("R7 counter now 6", {31'd0, rsp_late}, 32'd1);
    endtask

    task automatic t_auth_fail;
        send(1'b1, 2, 32'd100, 1'b0);
        check("R8 fail not accepted", {31'd0, rsp_accept}, 32'd0);
        check("R8 fail not late", {31'd0, rsp_late}, 32'd0);
        send(1'b1, 2, 32'd7, 1'b0);
        check("R8 state unchanged", {31'd0, rsp_late}, 32'd0);
    endtask

    task automatic t_window;
        cfg_win_size = 32'd4;
        send(1'b1, 3, 32'd20, 1'b1);
        check("R7 accept 20", {31'd0, rsp_accept}, 32'd1);
        send(1'b1, 3, 32'd17, 1'b1);
        check("R5 edge of window", {31'd0, rsp_late}, 32'd0);
        check("R10 in-window accept", {31'd0, rsp_accept}, 32'd1);
        send(1'b1, 3, 32'd16, 1'b1);
        check("R5 below window late", {31'd0, rsp_late}, 32'd1);
        cfg_win_size = 32'd0;
        send(1'b1, 3, 32'd20, 1'b0);
        check("R7 no lowering", {31'd0, rsp_late}, 32'd1);
        send(1'b1, 3, 32'd21, 1'b0);
        check("R7 counter at 21", {31'd0, rsp_late}, 32'd0);
    endtask

    task automatic t_saturate;
        cfg_win_size = 32'hFFFF_FFFF;
        send(1'b1, 4, 32'd0, 1'b1);
        check("R9 pn0 not late", {31'd0, rsp_late}, 32'd0);
        check("R9 pn0 accepted", {31'd0, rsp_accept}, 32'd1);
    endtask

    task automatic t_independent;
        cfg_win_size = 32'd0;
        send(1'b1, 5, 32'd50, 1'b1);
        check("R11 rx accept", {31'd0, rsp_accept}, 32'd1);
        send(1'b0, 5, 0, 1'b0);
        check("R11 tx unaffected", rsp_pn, 32'd1);
        check("R10 tx no accept", {31'd0, rsp_accept}, 32'd0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_tx_limit();
        t_rx_zero_window();
        t_auth_fail();
        t_window();
        t_saturate();
        t_independent();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule